// File: doc/BRIEF.md
# Dual-Edge Nibble Counter with Upper Cascade

This block is a 4-bit counter that raises a sticky overflow flag each time it wraps from 0xF to 0x0. The flag can drive an interrupt. A select input picks the increment source, one of two:

- **External pin.** The pin is first synchronised to the system clock. Every transition of the synchronised pin adds one to the count, whether it is a rising or a falling edge.
- **Software strobe.** Each cycle with the strobe high adds one, so an overflow can be raised on demand as a software interrupt.

Software may preload the counter with any 4-bit value. Preloading 0xF makes the very next counting event overflow the counter. With the pin selected, this turns the overflow flag and the interrupt enable into an edge-triggered external interrupt.

Each wrap of the nibble also advances an 8-bit upper stage by one. Together the two stages form a 12-bit count.

Top module: `nib_cascade_counter`

## Requirements
- R1: After synchronous reset the count is 0x0, the 12-bit count is 0x000, and both the overflow flag and the interrupt are 0.
- R2: With src_sel = 1 (strobe source), each clock cycle with sw_strobe high adds exactly one to the count at that clock edge.
- R3: With src_sel = 0 (pin source), each rising edge and each falling edge of ext_pin adds exactly one to the count. The count changes within three clock cycles of the pin change, after a two-flop synchroniser.
- R4: The unselected source has no effect: the strobe is ignored while the pin source is selected, and pin edges are ignored while the strobe source is selected.
- R5: A cycle with load_en high sets the count to load_val at the next edge. A load overrides an increment requested in the same cycle, and such a cycle raises no overflow.
- R6: An increment from 0xF wraps the count to 0x0 and sets the overflow flag at the same clock edge.
- R7: The overflow flag stays set until a cycle with flag_clr high. When a new overflow and a clear fall in the same cycle, the flag ends up set.
- R8: irq equals the overflow flag AND irq_en.
- R9: The 8-bit upper stage advances by one only at the edge where the nibble wraps, and wide_count = {upper[7:0], count[3:0]}.
- R10: With the pin source selected and the count preloaded to 0xF, a single pin edge sets the overflow flag. This serves as an edge-triggered external interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external count pin; both edges count |
| sw_strobe | input | 1 | Software count strobe, one count per high cycle |
| src_sel | input | 1 | Increment source: 0 = pin, 1 = strobe |
| load_en | input | 1 | Preload the nibble with load_val |
| load_val | input | 4 | Preload value |
| flag_clr | input | 1 | Clear the overflow flag (write-one) |
| irq_en | input | 1 | Interrupt enable |
| count | output | 4 | Nibble count |
| wide_count | output | 12 | Combined {upper, nibble} count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with its default parameters: a 4-bit nibble, an 8-bit upper stage and two synchroniser flops. With a 4-bit nibble, a wrap is reachable within a handful of strobes. This puts the following cases in reach of a short vector table:
- a load colliding with a strobe;
- an overflow colliding with a flag clear;
- the upper stage advancing on each wrap.

With two synchroniser stages, the pin-to-count latency is short enough that the dual-edge and preload-to-0xF interrupt cases can be checked a few cycles after each pin toggle.

// File: rtl/nib_pkg.sv
package nib_pkg;
  typedef enum logic {
    SRC_PIN    = 1'b0,
    SRC_STROBE = 1'b1
  } src_e;
endpackage

// File: rtl/nib_edge_sync.sv
module nib_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic edge_pulse
);
  logic [STAGES-1:0] sr;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sr[STAGES-1];
  end

  // Any change of the synchronised level is one count event.
  assign edge_pulse = sr[STAGES-1] ^ prev;
endmodule

// File: rtl/nib_counter.sv
module nib_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         flag,
  output logic         carry
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  // Load wins: no carry when a load is present.
  assign carry = inc & ~ld & (cnt == MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (ld)       cnt <= ld_val;
      else if (inc) cnt <= cnt + 1'b1;
      if (carry)    flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assert_load_wins_R5: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt == $past(ld_val)));
  assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && cnt == MAXV) |=> (flag && cnt == '0));
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld) |=> $stable(cnt));
endmodule

// File: rtl/nib_upper.sv
module nib_upper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst)       val <= '0;
    else if (step) val <= val + 1'b1;
  end

  assert_upper_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(val));
  assert_upper_step_R9: assert property (@(posedge clk) disable iff (rst)
    step |=> (val == $past(val) + 1'b1));
endmodule

// File: rtl/nib_cascade_counter.sv
module nib_cascade_counter
  import nib_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int UP_W        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WIDE_W     = NIB_W + UP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_pin,
  input  logic              sw_strobe,
  input  logic              src_sel,
  input  logic              load_en,
  input  logic [NIB_W-1:0]  load_val,
  input  logic              flag_clr,
  input  logic              irq_en,
  output logic [NIB_W-1:0]  count,
  output logic [WIDE_W-1:0] wide_count,
  output logic              ovf_flag,
  output logic              irq
);
  src_e            src;
  logic            pin_edge;
  logic            inc;
  logic            carry;
  logic [UP_W-1:0] upper;

  assign src = src_e'(src_sel);

  nib_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_pin), .edge_pulse(pin_edge)
  );

  assign inc = (src == SRC_PIN) ? pin_edge : sw_strobe;

  nib_counter #(.W(NIB_W)) u_nib (
    .clk(clk), .rst(rst), .inc(inc), .ld(load_en), .ld_val(load_val),
    .clr(flag_clr), .cnt(count), .flag(ovf_flag), .carry(carry)
  );

  nib_upper #(.W(UP_W)) u_up (
    .clk(clk), .rst(rst), .step(carry), .val(upper)
  );

  assign wide_count = {upper, count};
  assign irq        = ovf_flag & irq_en;

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq);
endmodule

// File: tb/tb_nib_cascade_counter.sv
module tb_nib_cascade_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pin = 1'b0, sw_strobe = 1'b0, src_sel = 1'b1, load_en = 1'b0;
  logic [3:0] load_val = '0;
  logic flag_clr = 1'b0, irq_en = 1'b0;
  logic [3:0]  count;
  logic [11:0] wide_count;
  logic ovf_flag, irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nib_cascade_counter dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .sw_strobe(sw_strobe),
    .src_sel(src_sel), .load_en(load_en), .load_val(load_val),
    .flag_clr(flag_clr), .irq_en(irq_en), .count(count),
    .wide_count(wide_count), .ovf_flag(ovf_flag), .irq(irq)
  );

  // Vector: {ld, ld_val[3:0], strobe, clr, exp_cnt[3:0], exp_flag}
  localparam logic [11:0] VEC [10] = '{
    {1'b1, 4'hD, 1'b0, 1'b0, 4'hD, 1'b0},  // R5 load
    {1'b0, 4'h0, 1'b1, 1'b0, 4'hE, 1'b0},  // R2
    {1'b0, 4'h0, 1'b1, 1'b0, 4'hF, 1'b0},  // R2
    {1'b0, 4'h0, 1'b1, 1'b0, 4'h0, 1'b1},  // R6 wrap
    {1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1},  // R7 sticky
    {1'b0, 4'h0, 1'b0, 1'b1, 4'h0, 1'b0},  // R7 clear
    {1'b1, 4'hF, 1'b1, 1'b0, 4'hF, 1'b0},  // R5 load beats strobe
    {1'b0, 4'h0, 1'b1, 1'b1, 4'h0, 1'b1},  // R7 set beats clear
    {1'b0, 4'h0, 1'b0, 1'b1, 4'h0, 1'b0},  // R7 clear
    {1'b1, 4'h3, 1'b0, 1'b1, 4'h3, 1'b0}   // R5 load
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cycles(3);
    check("R1 count", {28'd0, count}, 32'h0);
    check("R1 wide", {20'd0, wide_count}, 32'h0);
    check("R1 flag", {31'd0, ovf_flag}, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    rst = 1'b0;

    // Vector walk, strobe source.
    src_sel = 1'b1;
    for (int i = 0; i < 10; i++) begin
      {load_en, load_val, sw_strobe, flag_clr} = VEC[i][11:5];
      @(negedge clk);
      {load_en, sw_strobe, flag_clr} = '0;
      check($sformatf("R2/R5/R6/R7 vec%0d cnt", i), {28'd0, count}, {28'd0, VEC[i][4:1]});
      check($sformatf("R6/R7 vec%0d flag", i), {31'd0, ovf_flag}, {31'd0, VEC[i][0]});
    end
    check("R9 wide after two wraps", {20'd0, wide_count}, 32'h023);

    // R4: pin edges ignored under strobe source.
    ext_pin = 1'b1; wait_cycles(4);
    ext_pin = 1'b0; wait_cycles(4);
    check("R4 pin ignored", {28'd0, count}, 32'h3);

    // R3: both edges count under pin source.
    src_sel = 1'b0; wait_cycles(2);
    ext_pin = 1'b1; wait_cycles(3);
    check("R3 rising edge", {28'd0, count}, 32'h4);
    ext_pin = 1'b0; wait_cycles(3);
    check("R3 falling edge", {28'd0, count}, 32'h5);

    // R4: strobe ignored under pin source.
    sw_strobe = 1'b1; wait_cycles(3); sw_strobe = 1'b0; wait_cycles(1);
    check("R4 strobe ignored", {28'd0, count}, 32'h5);

    // R10: preload F, one pin edge raises flag; R8 irq gating.
    load_en = 1'b1; load_val = 4'hF; @(negedge clk); load_en = 1'b0;
    check("R5 preload F", {28'd0, count}, 32'hF);
    check("R10 flag clear before edge", {31'd0, ovf_flag}, 32'h0);
    ext_pin = 1'b1; wait_cycles(3);
    check("R10 count wrapped", {28'd0, count}, 32'h0);
    check("R10 flag set by edge", {31'd0, ovf_flag}, 32'h1);
    check("R8 irq off when disabled", {31'd0, irq}, 32'h0);
    irq_en = 1'b1; #1;
    check("R8 irq on when enabled", {31'd0, irq}, 32'h1);
    check("R9 upper advanced", {20'd0, wide_count}, 32'h030);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R8 irq drops after clear", {31'd0, irq}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule